// File: doc/BRIEF.md
# Real-Time Clock Control and Output Unit

This block is the control and timing front end of a real-time clock. Two 32.768 kHz tick-enable streams arrive at its edge, one from an internal low-power source and one from an external crystal source. A clock-select field in the control word chooses which stream feeds a prescaler. The prescaler turns the chosen stream into one-cycle seconds pulses for the calendar logic, and it also reports which half of the current second is running and whether a seconds rollover is about to happen.

Software reaches the block through a simple register port with three addresses: a control word, an unlock key register and the time register. Writes that reach the time register pass through the block only while the time-write enable is set, and that enable can only be raised by the write that follows a two-word key sequence. A single output pin carries the alarm pulse, a one-hertz square wave or the selected tick stream. The pin is held low unless its enable bit is set. All state is cleared only by the power-on reset input.

The unlock engine is a state machine with three states. `UL_IDLE` has seen no key. `UL_KEY1` has seen the first key word. `UL_OPEN` has seen both key words in order. The transitions, each taken on a register write, are:
- first key at the key address: goes to `UL_KEY1` from any state.
- second key at the key address while in `UL_KEY1`: goes to `UL_OPEN`.
- any other write: returns to `UL_IDLE`. In `UL_OPEN` this write is the one allowed to raise the enable.

Top module: `rtc_ctl_unit`

## Requirements
- R1: After power-on reset (por_n low) the control word reads 0, so ON, the write enable, both select fields, the output enable and the status bits are all 0. pin_o, sec_pulse_o and time_wr_o are 0.
- R2: Clock select (control bits [3:2]): 00 selects tick_int_i and 01 selects tick_ext_i. Codes 10 and 11 stop the prescaler. The running bit (control bit 10) reads 1 exactly when ON (bit 0) is 1 and the select code is 00 or 01.
- R3: While running, the prescaler counts 32768 selected ticks. On the tick that completes the count, the counter wraps to zero and sec_pulse_o is high for the following cycle only.
- R4: The half-second bit (control bit 8) reads 0 while the count is below 16384 and reads 1 from 16384 to 32767.
- R5: The sync flag (control bit 9) reads 1 while the count is 32736 or more, which covers the last 32 ticks before the rollover, and reads 0 otherwise.
- R6: An accepted write to the time register (address 2) clears the count to zero on that edge, so the half-second bit and the sync flag read 0 afterwards.
- R7: Unlock consists of two consecutive writes to the key register (address 1): 32'hAA996655 and then 32'h556699AA. A write to the control word (address 0) with bit 1 set raises the write enable only when it is the very next write. Any other write between the two key words aborts the sequence.
- R8: Writing 1 to the write-enable bit has no effect unless the unlock sequence has just completed. Writing 0 always clears it.
- R9: While the write enable is 0, a write to the time register leaves time_wr_o low and the count untouched, and a write to ON leaves ON unchanged. While the enable is 1, time_wr_o is high in the write cycle and time_wdata_o carries the data.
- R10: pin_o is registered with one cycle of latency. It is 0 when the output enable (bit 6) is 0. Output select (bits [5:4]): 00 gives alarm_i, 01 gives the half-second bit (a one-hertz clock), 10 gives the selected tick while running, and 11 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_int_i | input | 1 | Tick enable from the internal low-power source |
| tick_ext_i | input | 1 | Tick enable from the external crystal source |
| alarm_i | input | 1 | Alarm pulse from the alarm matcher |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 key, 2 time |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data (control word at address 0, otherwise 0) |
| time_wr_o | output | 1 | Accepted write to the time register |
| time_wdata_o | output | 32 | Data forwarded to the time register |
| sec_pulse_o | output | 1 | One-cycle pulse once per second |
| pin_o | output | 1 | Output pin |

## Verification
If the unlock state machine is left in the wrong state, the effect shows on the very next control write: either the write enable fails to rise, or it rises without a key pair, and time_wr_o then disagrees at once on a time write. A prescaler count that is off by one or more moves the half-second and sync edges away from ticks 16384 and 32736 and moves the seconds pulse away from tick 32768, so the bench probes exactly those ticks and the ticks just before them. A select or output-enable bit that is latched wrongly reaches pin_o one cycle after the write.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_KEY  = 2'd1;
    localparam logic [ADDR_W-1:0] A_TIME = 2'd2;

    localparam int B_ON     = 0;
    localparam int B_WREN   = 1;
    localparam int B_CSEL   = 2;   // two bits
    localparam int B_OSEL   = 4;   // two bits
    localparam int B_OE     = 6;
    localparam int B_HALF   = 8;
    localparam int B_SYNC   = 9;
    localparam int B_RUN    = 10;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hAA99_6655;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h5566_99AA;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_KEY1 = 2'd1,
        UL_OPEN = 2'd2
    } unlock_t;

    typedef enum logic [1:0] {
        PIN_ALARM  = 2'd0,
        PIN_SECCLK = 2'd1,
        PIN_TICK   = 2'd2,
        PIN_NONE   = 2'd3
    } pin_src_t;
endpackage

// File: rtl/rtc_unlock_fsm.sv
module rtc_unlock_fsm
    import rtc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              key_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_o
);
    unlock_t state_q, state_d;
    logic    is_k1, is_k2;

    assign is_k1 = key_sel && (wdata == KEY_FIRST);
    assign is_k2 = key_sel && (wdata == KEY_SECOND);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                UL_IDLE: state_d = is_k1 ? UL_KEY1 : UL_IDLE;
                UL_KEY1: state_d = is_k2 ? UL_OPEN : (is_k1 ? UL_KEY1 : UL_IDLE);
                UL_OPEN: state_d = is_k1 ? UL_KEY1 : UL_IDLE;
                default: state_d = UL_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            UL_OPEN: open_o = 1'b1;
            default: open_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SYNC_TICKS    = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic tick,
    input  logic clear,
    output logic sec_pulse,
    output logic half,
    output logic sync
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(TICKS_PER_SEC - 1);
    localparam logic [CNT_W-1:0] HALF_AT = CNT_W'(TICKS_PER_SEC / 2);
    localparam logic [CNT_W-1:0] SYNC_AT = CNT_W'(TICKS_PER_SEC - SYNC_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             step, wrap;

    assign step = run && tick;
    assign wrap = step && (cnt_q == LAST);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q     <= '0;
            sec_pulse <= 1'b0;
        end else begin
            sec_pulse <= wrap && !clear;
            if (clear || wrap) cnt_q <= '0;
            else if (step)     cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half = (cnt_q >= HALF_AT);
    assign sync = (cnt_q >= SYNC_AT);
endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
    import rtc_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     oe,
    input  pin_src_t src,
    input  logic     alarm,
    input  logic     sec_clk,
    input  logic     tick_clk,
    output logic     pin
);
    logic pin_d;

    always_comb begin
        unique case (src)
            PIN_ALARM:  pin_d = alarm;
            PIN_SECCLK: pin_d = sec_clk;
            PIN_TICK:   pin_d = tick_clk;
            default:    pin_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pin <= 1'b0;
        else        pin <= oe && pin_d;
    end
endmodule

// File: rtl/rtc_ctl_unit.sv
module rtc_ctl_unit
    import rtc_ctl_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SYNC_TICKS    = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tick_int_i,
    input  logic              tick_ext_i,
    input  logic              alarm_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              time_wr_o,
    output logic [DATA_W-1:0] time_wdata_o,
    output logic              sec_pulse_o,
    output logic              pin_o
);
    logic       on_q, wren_q, oe_q;
    logic [1:0] clksel_q;
    pin_src_t   outsel_q;
    logic       ul_open, ctrl_wr, key_wr;
    logic       sel_tick, running, half, sync;

    assign ctrl_wr      = wr_en_i && (wr_addr_i == A_CTRL);
    assign key_wr       = (wr_addr_i == A_KEY);
    assign time_wr_o    = wr_en_i && (wr_addr_i == A_TIME) && wren_q;
    assign time_wdata_o = wr_data_i;

    rtc_unlock_fsm u_unlock (
        .clk    (clk),
        .por_n  (por_n),
        .wr_en  (wr_en_i),
        .key_sel(key_wr),
        .wdata  (wr_data_i),
        .open_o (ul_open)
    );

    // control word, power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            on_q     <= 1'b0;
            wren_q   <= 1'b0;
            oe_q     <= 1'b0;
            clksel_q <= 2'b00;
            outsel_q <= PIN_ALARM;
        end else if (ctrl_wr) begin
            wren_q   <= wr_data_i[B_WREN] && (wren_q || ul_open);
            if (wren_q) on_q <= wr_data_i[B_ON];
            oe_q     <= wr_data_i[B_OE];
            clksel_q <= wr_data_i[B_CSEL +: 2];
            outsel_q <= pin_src_t'(wr_data_i[B_OSEL +: 2]);
        end
    end

    always_comb begin
        unique case (clksel_q)
            2'b00:   sel_tick = tick_int_i;
            2'b01:   sel_tick = tick_ext_i;
            default: sel_tick = 1'b0;
        endcase
    end

    assign running = on_q && !clksel_q[1];

    rtc_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .SYNC_TICKS   (SYNC_TICKS)
    ) u_presc (
        .clk      (clk),
        .por_n    (por_n),
        .run      (running),
        .tick     (sel_tick),
        .clear    (time_wr_o),
        .sec_pulse(sec_pulse_o),
        .half     (half),
        .sync     (sync)
    );

    rtc_pin_mux u_pin (
        .clk     (clk),
        .por_n   (por_n),
        .oe      (oe_q),
        .src     (outsel_q),
        .alarm   (alarm_i),
        .sec_clk (half),
        .tick_clk(running && sel_tick),
        .pin     (pin_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_CTRL) begin
            rd_data_o[B_ON]         = on_q;
            rd_data_o[B_WREN]       = wren_q;
            rd_data_o[B_CSEL +: 2]  = clksel_q;
            rd_data_o[B_OSEL +: 2]  = outsel_q;
            rd_data_o[B_OE]         = oe_q;
            rd_data_o[B_HALF]       = half;
            rd_data_o[B_SYNC]       = sync;
            rd_data_o[B_RUN]        = running;
        end
    end
endmodule

// File: rtl/rtc_ctl_checker.sv
module rtc_ctl_checker (
    input logic clk,
    input logic por_n,
    input logic wren,
    input logic on,
    input logic oe,
    input logic csel_hi,
    input logic ul_open,
    input logic time_wr,
    input logic sec_pulse,
    input logic half,
    input logic sync,
    input logic pin
);
    p_wren_after_unlock_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wren) |-> $past(ul_open));

    p_time_wr_gated_r9: assert property (@(posedge clk) disable iff (!por_n)
        time_wr |-> wren);

    p_on_held_locked_r9: assert property (@(posedge clk) disable iff (!por_n)
        !wren |=> $stable(on));

    p_clear_half_r6: assert property (@(posedge clk) disable iff (!por_n)
        time_wr |=> !half && !sync);

    p_sync_in_half_r5: assert property (@(posedge clk) disable iff (!por_n)
        sync |-> half);

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!por_n)
        sec_pulse |=> !sec_pulse);

    p_reserved_stops_r2: assert property (@(posedge clk) disable iff (!por_n)
        csel_hi |=> !sec_pulse);

    p_pin_low_off_r10: assert property (@(posedge clk) disable iff (!por_n)
        !oe |=> !pin);
endmodule

bind rtc_ctl_unit rtc_ctl_checker u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .wren     (wren_q),
    .on       (on_q),
    .oe       (oe_q),
    .csel_hi  (clksel_q[1]),
    .ul_open  (ul_open),
    .time_wr  (time_wr_o),
    .sec_pulse(sec_pulse_o),
    .half     (half),
    .sync     (sync),
    .pin      (pin_o)
);

// File: tb/rtc_ctl_unit_bench.sv
module rtc_ctl_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] AC = 2'd0, AK = 2'd1, AT = 2'd2;
    localparam logic [31:0] K1 = 32'hAA996655, K2 = 32'h556699AA;

    // {oe, outsel[1:0], alarm, expected pin}
    localparam logic [4:0] PIN_VEC [8] = '{
        5'b0_00_1_0, 5'b1_00_1_1, 5'b1_00_0_0, 5'b1_01_1_0,
        5'b1_10_1_0, 5'b1_11_1_0, 5'b0_01_1_0, 5'b1_00_1_1
    };

    logic clk = 1'b0, por_n = 1'b0;
    logic tick_int = 1'b0, tick_ext = 1'b0, alarm = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [31:0] wr_data = '0, rd_data, time_wdata;
    logic time_wr, sec_pulse, pin;
    int checks = 0, errors = 0;
    bit done = 0;

    rtc_ctl_unit u_rtc_ctl_unit (
        .clk(clk), .por_n(por_n), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
        .alarm_i(alarm), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .time_wr_o(time_wr),
        .time_wdata_o(time_wdata), .sec_pulse_o(sec_pulse), .pin_o(pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ctrl(input logic on, input logic we,
                                         input logic [1:0] cs, input logic [1:0] os,
                                         input logic oe);
        logic [31:0] w = '0;
        w[0] = on; w[1] = we; w[3:2] = cs; w[5:4] = os; w[6] = oe;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr_time(input logic exp_acc, input string tag);
        wr_en = 1'b1; wr_addr = AT; wr_data = 32'h0000_1234;
        #1;
        check(tag, {31'd0, time_wr}, {31'd0, exp_acc});
        if (exp_acc) check({tag, " data"}, time_wdata, 32'h0000_1234);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rd_addr = AC; #1;
        check("R1 ctrl word", rd_data, 32'd0);
        check("R1 pin", {31'd0, pin}, 32'd0);
        check("R1 sec pulse", {31'd0, sec_pulse}, 32'd0);
        check("R1 time_wr", {31'd0, time_wr}, 32'd0);
        tick_int = 1'b1;

        // R10 table walk: counter stopped, half = 0
        for (int i = 0; i < 8; i++) begin
            alarm = PIN_VEC[i][1];
            wr(AC, ctrl(1'b0, 1'b0, 2'b00, PIN_VEC[i][3:2], PIN_VEC[i][4]));
            @(negedge clk);
            check($sformatf("R10 vector %0d", i), {31'd0, pin}, {31'd0, PIN_VEC[i][0]});
        end
        alarm = 1'b0;
        wr(AC, 32'd0);

        // R8: no unlock, enable stays 0
        wr(AC, ctrl(1'b0, 1'b1, 2'b00, 2'b00, 1'b0)); #1;
        check("R8 set without unlock", {31'd0, rd_data[1]}, 32'd0);
        // R9: locked writes ignored
        wr_time(1'b0, "R9 locked time write");
        wr(AC, ctrl(1'b1, 1'b0, 2'b00, 2'b00, 1'b0)); #1;
        check("R9 ON locked", {31'd0, rd_data[0]}, 32'd0);

        // R7: aborted sequence
        wr(AK, K1); wr(AC, 32'd0); wr(AK, K2);
        wr(AC, ctrl(1'b0, 1'b1, 2'b00, 2'b00, 1'b0)); #1;
        check("R7 aborted unlock", {31'd0, rd_data[1]}, 32'd0);
        // R7: valid sequence
        wr(AK, K1); wr(AK, K2);
        wr(AC, ctrl(1'b0, 1'b1, 2'b00, 2'b00, 1'b0)); #1;
        check("R7 unlock sets enable", {31'd0, rd_data[1]}, 32'd1);
        wr(AC, ctrl(1'b1, 1'b1, 2'b00, 2'b00, 1'b0)); #1;
        check("R9 ON written unlocked", {31'd0, rd_data[0]}, 32'd1);
        check("R2 running internal", {31'd0, rd_data[10]}, 32'd1);

        // R6/R3/R4/R5 count walk (one tick per cycle)
        wr_time(1'b1, "R9 unlocked time write"); #1;
        check("R6 half after clear", {31'd0, rd_data[8]}, 32'd0);
        check("R6 sync after clear", {31'd0, rd_data[9]}, 32'd0);
        repeat (16383) @(negedge clk); #1;
        check("R4 half at 16383", {31'd0, rd_data[8]}, 32'd0);
        @(negedge clk); #1;
        check("R4 half at 16384", {31'd0, rd_data[8]}, 32'd1);
        repeat (16351) @(negedge clk); #1;
        check("R5 sync at 32735", {31'd0, rd_data[9]}, 32'd0);
        @(negedge clk); #1;
        check("R5 sync at 32736", {31'd0, rd_data[9]}, 32'd1);
        check("R3 no pulse early", {31'd0, sec_pulse}, 32'd0);
        repeat (31) @(negedge clk); #1;
        check("R3 no pulse at 32767", {31'd0, sec_pulse}, 32'd0);
        @(negedge clk); #1;
        check("R3 pulse on wrap", {31'd0, sec_pulse}, 32'd1);
        check("R3 half after wrap", {31'd0, rd_data[8]}, 32'd0);
        @(negedge clk); #1;
        check("R3 pulse one cycle", {31'd0, sec_pulse}, 32'd0);

        // R6 mid-second clear
        repeat (20000) @(negedge clk); #1;
        check("R6 half before clear", {31'd0, rd_data[8]}, 32'd1);
        wr_time(1'b1, "R6 accepted write"); #1;
        check("R6 half cleared", {31'd0, rd_data[8]}, 32'd0);

        // R2 reserved select stops counting
        wr(AC, ctrl(1'b1, 1'b1, 2'b10, 2'b10, 1'b1)); #1;
        check("R2 reserved not running", {31'd0, rd_data[10]}, 32'd0);
        repeat (20000) @(negedge clk); #1;
        check("R2 reserved holds count", {31'd0, rd_data[8]}, 32'd0);
        check("R10 tick pin stopped", {31'd0, pin}, 32'd0);

        // R2 external source selected, internal ignored
        wr(AC, ctrl(1'b1, 1'b1, 2'b01, 2'b10, 1'b1));
        repeat (20000) @(negedge clk); #1;
        check("R2 ext idle no count", {31'd0, rd_data[8]}, 32'd0);
        check("R10 tick pin ext idle", {31'd0, pin}, 32'd0);
        tick_ext = 1'b1;
        @(negedge clk); #1;
        check("R10 tick pin ext active", {31'd0, pin}, 32'd1);
        repeat (20000) @(negedge clk); #1;
        check("R2 ext counting", {31'd0, rd_data[8]}, 32'd1);

        // R10 seconds clock on pin
        wr(AC, ctrl(1'b1, 1'b1, 2'b00, 2'b01, 1'b1));
        @(negedge clk); #1;
        check("R10 sec clock high", {31'd0, pin}, 32'd1);
        wr_time(1'b1, "R6 write before sec clock");
        @(negedge clk); #1;
        check("R10 sec clock low", {31'd0, pin}, 32'd0);

        // R8 clear always allowed, then locked again
        wr(AC, ctrl(1'b1, 1'b0, 2'b00, 2'b01, 1'b1)); #1;
        check("R8 clear enable", {31'd0, rd_data[1]}, 32'd0);
        wr_time(1'b0, "R9 relocked time write");
        wr(AC, ctrl(1'b0, 1'b0, 2'b00, 2'b01, 1'b1)); #1;
        check("R9 ON held relocked", {31'd0, rd_data[0]}, 32'd1);

        finish_run();
    end
endmodule